// File: doc/BRIEF.md
# Up-Counting Interval Timer

A single timer/counter peripheral with a 28-bit up-counter, programmed over a simple 32-bit register bus. Software loads an end marker and a tick divisor, then sets the enable bit. The count then advances once per divided tick. When the count equals the end marker, or when it would pass the all-ones 28-bit value, it returns to zero and latches an interrupt pending flag.

A single mode bit chooses what happens after such a wrap. In one-shot mode the timer halts, and the enable bit reads back as clear. In free-running mode it keeps counting from zero. The interrupt line is the pending flag gated by an interrupt enable. Software clears the flag by writing a one to it. The count register can be written at any time, for example to preload it before starting.

The control path is a two-state machine. ST_IDLE leaves the counter frozen. ST_RUN advances it. It has three transitions:
- START (ST_IDLE to ST_RUN): a control write with the enable bit set.
- STOP (ST_RUN to ST_IDLE): a control write with the enable bit clear.
- HALT (ST_RUN to ST_IDLE): a wrap while in one-shot mode.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: The register offsets, decoded from address bits 3:2, are:

  | Offset | Register |
  |--------|----------|
  | 0x0 | End marker (28 bits) |
  | 0x4 | Count (28 bits) |
  | 0x8 | Control |
  | 0xC | Interrupt |

  Unused bits read 0. A count write replaces the live count, and the count reads back zero-extended.
- R3: The count rises once per tick only while the timer runs, which control bit 28 shows. A control write with bit 28 at 0 stops it. A stopped count holds its value.
- R4: Control bits 15:0 hold the divisor D. A tick occurs every D input clocks, and D of 0 or 1 gives one tick per clock.
- R5: A tick while the count equals the end marker P sets the count to 0 and sets pending. Starting from a count of 0, the first wrap lands (P+1)·max(D,1) clocks after the enabling write.
- R6: A tick at count 0x0FFFFFFF wraps the count to 0 and sets pending, even when the end marker is below the count.
- R7: Control bit 24 is the mode bit.
  - At 0, a wrap halts the timer and control bit 28 reads 0 afterwards.
  - At 1, counting continues after the wrap.
- R8: In the interrupt register, bit 20 is the interrupt enable and bit 16 is the pending flag. `irq_o` is high only when both are set.
- R9: Writing the interrupt register with bit 16 at 1 clears pending. Writing it with bit 16 at 0 leaves pending unchanged.
- R10: When a wrap and a pending clear fall in the same cycle, pending ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address, bits 3:2 decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench keeps the default parameters: a 28-bit count and a 16-bit divisor field. A preload of the count register to just below 0x0FFFFFFF lets the 28-bit limit wrap be observed within a few clocks instead of 2^28 ticks. Small end markers combined with divisors of 0 through 4 place the first wrap at an exactly predicted cycle in both modes. A wrap is lined up with a pending clear on the same edge to check that the set takes priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {ST_IDLE, ST_RUN} run_state_e;

    localparam int REG_SEL_W = 2;
    localparam logic [REG_SEL_W-1:0] SEL_END  = 2'd0;
    localparam logic [REG_SEL_W-1:0] SEL_CNT  = 2'd1;
    localparam logic [REG_SEL_W-1:0] SEL_CTRL = 2'd2;
    localparam logic [REG_SEL_W-1:0] SEL_IRQ  = 2'd3;

    localparam int BIT_RUN  = 28;
    localparam int BIT_MODE = 24;
    localparam int BIT_IEN  = 20;
    localparam int BIT_PEND = 16;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pre_q;
    logic             single;

    assign single = (div <= DIV_W'(1));
    assign tick   = run && !restart && (single || pre_q == div - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + DIV_W'(1);
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_we,
    input  logic             ctrl_en,
    input  logic             mode,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] end_mark,
    output logic [CNT_W-1:0] count,
    output run_state_e       state,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    run_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: START, STOP, HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctrl_we && ctrl_en) state_d = ST_RUN;
            ST_RUN: begin
                if (ctrl_we && !ctrl_en)  state_d = ST_IDLE;
                else if (wrap && !mode)   state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    assign wrap  = tick && (cnt_q == end_mark || cnt_q == CNT_MAX);
    assign count = cnt_q;
    assign state = state_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_we) cnt_q <= cnt_wdata;
        else if (wrap)   cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 28,
    parameter int DIV_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              running,
    input  logic              wrap,
    output logic [CNT_W-1:0]  end_mark,
    output logic [DIV_W-1:0]  div,
    output logic              mode,
    output logic              ien,
    output logic              pend,
    output logic              ctrl_we,
    output logic              ctrl_en,
    output logic              cnt_we
);
    logic [REG_SEL_W-1:0] sel;
    logic                 wr, irq_we;
    logic                 unused_bits;

    assign sel     = bus_addr[3:2];
    assign wr      = bus_sel && bus_we;
    assign ctrl_we = wr && sel == SEL_CTRL;
    assign cnt_we  = wr && sel == SEL_CNT;
    assign irq_we  = wr && sel == SEL_IRQ;
    assign ctrl_en = bus_wdata[BIT_RUN];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_mark <= '0;
            div      <= '0;
            mode     <= 1'b0;
            ien      <= 1'b0;
            pend     <= 1'b0;
        end else begin
            if (wr && sel == SEL_END) end_mark <= bus_wdata[CNT_W-1:0];
            if (ctrl_we) begin
                div  <= bus_wdata[DIV_W-1:0];
                mode <= bus_wdata[BIT_MODE];
            end
            if (irq_we) ien <= bus_wdata[BIT_IEN];
            if (wrap)                             pend <= 1'b1;
            else if (irq_we && bus_wdata[BIT_PEND]) pend <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_END:  bus_rdata[CNT_W-1:0] = end_mark;
            SEL_CNT:  bus_rdata[CNT_W-1:0] = count;
            SEL_CTRL: begin
                bus_rdata[BIT_RUN]     = running;
                bus_rdata[BIT_MODE]    = mode;
                bus_rdata[DIV_W-1:0]   = div;
            end
            SEL_IRQ: begin
                bus_rdata[BIT_IEN]  = ien;
                bus_rdata[BIT_PEND] = pend;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 28,
    parameter int DIV_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    logic [CNT_W-1:0] cnt_q, end_q;
    logic [DIV_W-1:0] div_q;
    logic             mode_q, ien_q, pend_q;
    logic             ctrl_we_s, ctrl_en_s, cnt_we_s, tick_s, wrap_s, running;
    run_state_e       state_q;

    assign running = (state_q == ST_RUN);
    assign irq_o   = pend_q & ien_q;

    tmr_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(cnt_q), .running(running), .wrap(wrap_s),
        .end_mark(end_q), .div(div_q), .mode(mode_q), .ien(ien_q), .pend(pend_q),
        .ctrl_we(ctrl_we_s), .ctrl_en(ctrl_en_s), .cnt_we(cnt_we_s)
    );

    tmr_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(running), .restart(ctrl_we_s),
        .div(div_q), .tick(tick_s)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_s), .ctrl_we(ctrl_we_s),
        .ctrl_en(ctrl_en_s), .mode(mode_q), .cnt_we(cnt_we_s),
        .cnt_wdata(bus_wdata[CNT_W-1:0]), .end_mark(end_q),
        .count(cnt_q), .state(state_q), .wrap(wrap_s)
    );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             pend,
    input logic             mode,
    input logic             tick,
    input logic             wrap,
    input logic             cnt_we,
    input logic [CNT_W-1:0] count,
    input run_state_e       state
);
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap && !cnt_we) |=> count == $past(count) + CNT_W'(1));
    assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cnt_we) |=> $stable(count));
    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !cnt_we) |=> count == '0);
    assert_wrap_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> pend);
    assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !mode) |=> state == ST_IDLE);
    assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && mode) |=> state == ST_RUN);
    assert_irq_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend);
endmodule

bind tick_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .pend(pend_q), .mode(mode_q),
    .tick(tick_s), .wrap(wrap_s), .cnt_we(cnt_we_s), .count(cnt_q), .state(state_q)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
    localparam logic [3:0] A_END = 4'h0, A_CNT = 4'h4, A_CTRL = 4'h8, A_IRQ = 4'hC;
    localparam logic [31:0] RUN = 32'h1000_0000, MODE = 32'h0100_0000;
    localparam logic [31:0] IEN = 32'h0010_0000, PEND = 32'h0001_0000;

    typedef struct packed {
        logic [27:0] per;
        logic [15:0] div;
        logic        mode;
        logic [31:0] cycles;
    } vec_t;
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{per: 28'd3, div: 16'd1, mode: 1'b0, cycles: 32'd4},
        '{per: 28'd0, div: 16'd1, mode: 1'b1, cycles: 32'd1},
        '{per: 28'd5, div: 16'd3, mode: 1'b1, cycles: 32'd18},
        '{per: 28'd2, div: 16'd0, mode: 1'b0, cycles: 32'd3},
        '{per: 28'd7, div: 16'd2, mode: 1'b0, cycles: 32'd16},
        '{per: 28'd1, div: 16'd4, mode: 1'b1, cycles: 32'd8}
    };

    logic clk = 1'b0, rst_n = 1'b0, bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, rd;
    logic irq_o;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tick_timer uut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rdreg(A_END, rd);  check("R1 end", rd, 0);
        rdreg(A_CNT, rd);  check("R1 cnt", rd, 0);
        rdreg(A_CTRL, rd); check("R1 ctrl", rd, 0);
        rdreg(A_IRQ, rd);  check("R1 irq reg", rd, 0);
        check("R1 irq_o", {31'b0, irq_o}, 0);
        // R2 readback and truncation
        wr(A_END, 32'hFFFF_FFFF); rdreg(A_END, rd); check("R2 end", rd, 32'h0FFF_FFFF);
        wr(A_CNT, 32'hABCD_EF12); rdreg(A_CNT, rd); check("R2 cnt", rd, 32'h0BCD_EF12);

        // R4 R5 R7: table of first-wrap timing
        for (int i = 0; i < NV; i++) begin
            int n;
            wr(A_CTRL, 0); wr(A_IRQ, IEN | PEND); wr(A_CNT, 0);
            wr(A_END, {4'b0, VECS[i].per});
            wr(A_CTRL, RUN | (VECS[i].mode ? MODE : 0) | {16'b0, VECS[i].div});
            rdreg(A_CTRL, rd);
            check("R4 ctrl readback", rd, RUN | (VECS[i].mode ? MODE : 0) | {16'b0, VECS[i].div});
            n = 0;
            while (!irq_o && n < 500) begin edges(1); n++; end
            check("R5 R4 cycles to wrap", n, VECS[i].cycles);
            rdreg(A_CNT, rd);  check("R5 cnt zero", rd, 0);
            rdreg(A_IRQ, rd);  check("R5 pending", rd, IEN | PEND);
            rdreg(A_CTRL, rd); check("R7 run bit", rd & RUN, VECS[i].mode ? RUN : 0);
            if (!VECS[i].mode) begin
                edges(3); rdreg(A_CNT, rd); check("R7 halted", rd, 0);
            end
        end

        // R6 28-bit limit wrap, free-running
        wr(A_CTRL, 0); wr(A_IRQ, IEN | PEND); wr(A_END, 5); wr(A_CNT, 32'h0FFF_FFFD);
        wr(A_CTRL, RUN | MODE | 1);
        edges(2); rdreg(A_CNT, rd); check("R6 at max", rd, 32'h0FFF_FFFF);
        check("R6 no irq yet", {31'b0, irq_o}, 0);
        edges(1); rdreg(A_CNT, rd); check("R6 wrapped", rd, 0);
        check("R6 irq", {31'b0, irq_o}, 1);
        edges(1); rdreg(A_CNT, rd); check("R7 continues", rd, 1);

        // R3 frozen while stopped, counts while running, stop freezes
        wr(A_CTRL, 0); wr(A_CNT, 10);
        edges(3); rdreg(A_CNT, rd); check("R3 idle hold", rd, 10);
        wr(A_CTRL, RUN | MODE | 1);
        edges(3); rdreg(A_CNT, rd); check("R3 running", rd, 13);
        wr(A_CTRL, 0); rdreg(A_CNT, rd); check("R3 stop", rd, 13);
        edges(5); rdreg(A_CNT, rd); check("R3 stopped hold", rd, 13);
        rdreg(A_CTRL, rd); check("R3 ctrl off", rd, 0);

        // R8 R9 gating and clear (pending still set from R6 test)
        wr(A_IRQ, 0); rdreg(A_IRQ, rd); check("R8 pend kept", rd, PEND);
        check("R8 gated off", {31'b0, irq_o}, 0);
        wr(A_IRQ, IEN); rdreg(A_IRQ, rd); check("R9 bit16 zero keeps", rd, IEN | PEND);
        check("R8 irq on", {31'b0, irq_o}, 1);
        wr(A_IRQ, IEN | PEND); rdreg(A_IRQ, rd); check("R9 cleared", rd, IEN);
        check("R9 irq low", {31'b0, irq_o}, 0);

        // R10 wrap and clear on the same edge
        wr(A_CNT, 0); wr(A_END, 3); wr(A_CTRL, RUN | 1);
        edges(3); rdreg(A_IRQ, rd); check("R10 before", rd, IEN);
        wr(A_IRQ, IEN | PEND);
        rdreg(A_IRQ, rd); check("R10 set wins", rd, IEN | PEND);
        rdreg(A_CTRL, rd); check("R10 halted", rd, 32'h1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule